// File: doc/BRIEF.md
# Processor External Interrupt Entry Controller

This block sits beside a processor pipeline and decides when an external interrupt diverts execution. A parameterised set of request lines (32 by default) feeds a sticky pending register. Each request line `n` drives bit `n` of the pending register and is qualified by bit `n` of a mask register. A two-bit status register holds a global enable in bit 0 and a saved copy of that enable in bit 1. Software reaches the pending, mask, status and base registers through a small CSR port. Pending bits are cleared by writing ones to them.

The decision is made only at instruction boundaries, which the pipeline signals with a one-cycle strobe. When the controller takes an interrupt, it performs three actions in the same cycle. It redirects the PC to the exception base plus the interrupt exception ID times 32. It requests a write of the current PC into the return-address general register (index 30). It rewrites the status register to 0x2 on the following clock edge.

A boundary check runs only while a check is armed. Any request line seen high arms a check, and each boundary strobe uses the armed check up. Lines that stay high therefore re-arm the check at every later boundary. Once all lines are low, one boundary is enough to disarm the check.

Top module: `irq_entry_ctrl`

## Requirements
- R1: After reset the pending, mask, status and base registers all read 0, and no redirect is requested.
- R2: A request line `n` that is high at a rising clock edge sets pending bit `n`, which is readable in the next cycle. CSR addresses: 0 = pending, 1 = mask, 2 = status, 3 = base.
- R3: A pending bit stays set after its request line returns to 0.
- R4: Writing the pending address clears every pending bit written as 1 and leaves the other bits unchanged. If a request line is high in the same cycle, its bit stays set.
- R5: An interrupt is taken only when status bit 0 is 1 and (mask AND pending) is nonzero. A masked request or a cleared enable produces no entry.
- R6: On entry, `excAddrWrEn` is 1, `excAddrIdx` is 30 and `excAddrData` equals `curPc`, all in the boundary cycle.
- R7: On entry, `redirectValid` is 1 and `redirectPc` equals base + EXC_ID*32. With the default ID of 6 this is base + 0xC0.
- R8: On the clock edge that ends an entry cycle, the status register becomes 0x2. Bit 0 is cleared and bit 1 is set.
- R9: The base register ignores writes to its low 8 bits, which always read 0.
- R10: A boundary check is armed by any request line seen high and disarmed by a boundary strobe. After all lines drop and one boundary passes, later enable writes cause no entry until some line goes high again.
- R11: No entry and no return-address write happen in a cycle without the boundary strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqLines | input | NUM_LINES | External request levels |
| csrWrEn | input | 1 | CSR write strobe |
| csrAddr | input | 2 | CSR select: 0 pending, 1 mask, 2 status, 3 base |
| csrWrData | input | XLEN | CSR write data |
| csrRdData | output | XLEN | CSR read data for `csrAddr` (combinational) |
| instrDone | input | 1 | Instruction boundary strobe |
| curPc | input | XLEN | PC of the next instruction at the boundary |
| redirectValid | output | 1 | Take-interrupt PC redirect |
| redirectPc | output | XLEN | Handler address |
| excAddrWrEn | output | 1 | Return-address register write enable |
| excAddrIdx | output | 5 | Index of the return-address register (30) |
| excAddrData | output | XLEN | Return address to write |

## Verification
The hardest state to reach from the ports is a disarmed check: pending and mask overlap and the enable is set, yet the controller must stay silent. The bench reaches it in several steps. It holds a masked line high with the enable cleared, then drops the line. It then issues one boundary strobe while the enable is still 0, which uses up the armed check. Only after that does it write the enable. A final boundary shows no entry, and a fresh one-cycle pulse on a different line then re-arms the check and produces entry.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

  typedef enum logic [1:0] {
    CSR_PEND = 2'd0,
    CSR_MASK = 2'd1,
    CSR_STAT = 2'd2,
    CSR_BASE = 2'd3
  } csr_sel_t;

  typedef struct packed {
    logic wrPend;
    logic wrMask;
    logic wrStat;
    logic wrBase;
    logic takeIrq;
  } ctrl_strobes_t;

  localparam int STAT_W = 2;
  localparam logic [STAT_W-1:0] STAT_ON_ENTRY = 2'b10;

endpackage

// File: rtl/irq_entry_ctrl_fsm.sv
module irq_entry_ctrl_fsm
  import irq_entry_pkg::*;
#(
  parameter int NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] irqLines,
  input  logic                 instrDone,
  input  logic                 csrWrEn,
  input  logic [1:0]           csrAddr,
  input  logic                 maskedAny,
  input  logic                 enableBit,
  output ctrl_strobes_t        strobes
);

  logic armed;
  logic anyLine;
  csr_sel_t sel;

  assign anyLine = |irqLines;
  assign sel     = csr_sel_t'(csrAddr);

  // A check is armed while lines are seen high; each boundary consumes it.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed <= 1'b0;
    end else begin
      armed <= (armed & ~instrDone) | anyLine;
    end
  end

  always_comb begin
    strobes         = '0;
    strobes.wrPend  = csrWrEn && (sel == CSR_PEND);
    strobes.wrMask  = csrWrEn && (sel == CSR_MASK);
    strobes.wrStat  = csrWrEn && (sel == CSR_STAT);
    strobes.wrBase  = csrWrEn && (sel == CSR_BASE);
    strobes.takeIrq = instrDone && armed && enableBit && maskedAny;
  end

endmodule

// File: rtl/irq_entry_datapath.sv
module irq_entry_datapath
  import irq_entry_pkg::*;
#(
  parameter int NUM_LINES  = 32,
  parameter int XLEN       = 32,
  parameter int EXC_ID     = 6,
  parameter int ALIGN_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrl_strobes_t        strobes,
  input  logic [NUM_LINES-1:0] irqLines,
  input  logic [1:0]           csrAddr,
  input  logic [XLEN-1:0]      csrWrData,
  output logic [XLEN-1:0]      csrRdData,
  output logic [XLEN-1:0]      vectorPc,
  output logic                 maskedAny,
  output logic                 enableBit,
  output logic [NUM_LINES-1:0] pendState,
  output logic [NUM_LINES-1:0] maskState,
  output logic [STAT_W-1:0]    statState,
  output logic [XLEN-1:0]      baseState
);

  localparam int HI_W = XLEN - ALIGN_BITS;
  localparam logic [XLEN-1:0] VEC_OFF = XLEN'(EXC_ID * 32);

  logic [HI_W-1:0] baseHi;

  // Pending: per-bit sticky set, write-one-to-clear, set wins.
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_pend
    always_ff @(posedge clk) begin
      if (!rstN) begin
        pendState[i] <= 1'b0;
      end else if (irqLines[i]) begin
        pendState[i] <= 1'b1;
      end else if (strobes.wrPend && csrWrData[i]) begin
        pendState[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskState <= '0;
      statState <= '0;
      baseHi    <= '0;
    end else begin
      if (strobes.wrMask) maskState <= csrWrData[NUM_LINES-1:0];
      if (strobes.takeIrq)     statState <= STAT_ON_ENTRY;
      else if (strobes.wrStat) statState <= csrWrData[STAT_W-1:0];
      if (strobes.wrBase) baseHi <= csrWrData[XLEN-1:ALIGN_BITS];
    end
  end

  assign baseState = {baseHi, {ALIGN_BITS{1'b0}}};
  assign vectorPc  = baseState + VEC_OFF;
  assign maskedAny = |(maskState & pendState);
  assign enableBit = statState[0];

  always_comb begin
    csrRdData = '0;
    unique case (csr_sel_t'(csrAddr))
      CSR_PEND: csrRdData = XLEN'(pendState);
      CSR_MASK: csrRdData = XLEN'(maskState);
      CSR_STAT: csrRdData = XLEN'(statState);
      CSR_BASE: csrRdData = baseState;
      default:  csrRdData = '0;
    endcase
  end

endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
  import irq_entry_pkg::*;
#(
  parameter int NUM_LINES  = 32,
  parameter int XLEN       = 32,
  parameter int EXC_ID     = 6,
  parameter int ALIGN_BITS = 8,
  parameter int RET_REG    = 30
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] irqLines,
  input  logic                 csrWrEn,
  input  logic [1:0]           csrAddr,
  input  logic [XLEN-1:0]      csrWrData,
  output logic [XLEN-1:0]      csrRdData,
  input  logic                 instrDone,
  input  logic [XLEN-1:0]      curPc,
  output logic                 redirectValid,
  output logic [XLEN-1:0]      redirectPc,
  output logic                 excAddrWrEn,
  output logic [4:0]           excAddrIdx,
  output logic [XLEN-1:0]      excAddrData
);

  ctrl_strobes_t          strobes;
  logic                   maskedAny;
  logic                   enableBit;
  logic [XLEN-1:0]        vectorPc;
  logic [NUM_LINES-1:0]   pendState;
  logic [NUM_LINES-1:0]   maskState;
  logic [STAT_W-1:0]      statState;
  logic [XLEN-1:0]        baseState;

  irq_entry_ctrl_fsm #(.NUM_LINES(NUM_LINES)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .irqLines  (irqLines),
    .instrDone (instrDone),
    .csrWrEn   (csrWrEn),
    .csrAddr   (csrAddr),
    .maskedAny (maskedAny),
    .enableBit (enableBit),
    .strobes   (strobes)
  );

  irq_entry_datapath #(
    .NUM_LINES (NUM_LINES),
    .XLEN      (XLEN),
    .EXC_ID    (EXC_ID),
    .ALIGN_BITS(ALIGN_BITS)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .irqLines  (irqLines),
    .csrAddr   (csrAddr),
    .csrWrData (csrWrData),
    .csrRdData (csrRdData),
    .vectorPc  (vectorPc),
    .maskedAny (maskedAny),
    .enableBit (enableBit),
    .pendState (pendState),
    .maskState (maskState),
    .statState (statState),
    .baseState (baseState)
  );

  assign redirectValid = strobes.takeIrq;
  assign redirectPc    = vectorPc;
  assign excAddrWrEn   = strobes.takeIrq;
  assign excAddrIdx    = 5'(RET_REG);
  assign excAddrData   = curPc;

endmodule

// File: rtl/irq_entry_ctrl_chk.sv
module irq_entry_ctrl_chk #(
  parameter int NUM_LINES  = 32,
  parameter int XLEN       = 32,
  parameter int ALIGN_BITS = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_LINES-1:0] irqLines,
  input logic                 csrWrEn,
  input logic [1:0]           csrAddr,
  input logic                 instrDone,
  input logic [XLEN-1:0]      curPc,
  input logic                 redirectValid,
  input logic                 excAddrWrEn,
  input logic [XLEN-1:0]      excAddrData,
  input logic [NUM_LINES-1:0] pendState,
  input logic [NUM_LINES-1:0] maskState,
  input logic [1:0]           statState,
  input logic [XLEN-1:0]      baseState
);

  p_line_sets_pending_r2: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((pendState & $past(irqLines)) == $past(irqLines)));

  p_pending_sticky_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(csrWrEn && csrAddr == 2'd0) |=> ((pendState & $past(pendState)) == $past(pendState)));

  p_take_qualified_r5: assert property (@(posedge clk) disable iff (!rstN)
    redirectValid |-> (statState[0] && ((maskState & pendState) != '0)));

  p_return_addr_r6: assert property (@(posedge clk) disable iff (!rstN)
    redirectValid |-> (excAddrWrEn && excAddrData == curPc));

  p_status_on_entry_r8: assert property (@(posedge clk) disable iff (!rstN)
    redirectValid |=> (statState == 2'b10));

  p_base_aligned_r9: assert property (@(posedge clk) disable iff (!rstN)
    baseState[ALIGN_BITS-1:0] == '0);

  p_boundary_only_r11: assert property (@(posedge clk) disable iff (!rstN)
    !instrDone |-> (!redirectValid && !excAddrWrEn));

endmodule

bind irq_entry_ctrl irq_entry_ctrl_chk #(
  .NUM_LINES (NUM_LINES),
  .XLEN      (XLEN),
  .ALIGN_BITS(ALIGN_BITS)
) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .irqLines      (irqLines),
  .csrWrEn       (csrWrEn),
  .csrAddr       (csrAddr),
  .instrDone     (instrDone),
  .curPc         (curPc),
  .redirectValid (redirectValid),
  .excAddrWrEn   (excAddrWrEn),
  .excAddrData   (excAddrData),
  .pendState     (pendState),
  .maskState     (maskState),
  .statState     (statState),
  .baseState     (baseState)
);

// File: tb/irq_entry_ctrl_tb.sv
module irq_entry_ctrl_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] irqLines = '0;
  logic        csrWrEn = 1'b0;
  logic [1:0]  csrAddr = '0;
  logic [31:0] csrWrData = '0;
  logic [31:0] csrRdData;
  logic        instrDone = 1'b0;
  logic [31:0] curPc = '0;
  logic        redirectValid;
  logic [31:0] redirectPc;
  logic        excAddrWrEn;
  logic [4:0]  excAddrIdx;
  logic [31:0] excAddrData;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_entry_ctrl u_dut (
    .clk(clk), .rstN(rstN), .irqLines(irqLines), .csrWrEn(csrWrEn),
    .csrAddr(csrAddr), .csrWrData(csrWrData), .csrRdData(csrRdData),
    .instrDone(instrDone), .curPc(curPc), .redirectValid(redirectValid),
    .redirectPc(redirectPc), .excAddrWrEn(excAddrWrEn), .excAddrIdx(excAddrIdx),
    .excAddrData(excAddrData)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic csrWrite(input logic [1:0] a, input logic [31:0] d);
    csrWrEn = 1'b1; csrAddr = a; csrWrData = d;
    @(posedge clk); @(negedge clk);
    csrWrEn = 1'b0; csrWrData = '0;
  endtask

  task automatic csrRead(input logic [1:0] a, output logic [31:0] d);
    csrAddr = a; #1; d = csrRdData;
  endtask

  task automatic pulseLines(input logic [31:0] v);
    irqLines = v;
    @(posedge clk); @(negedge clk);
    irqLines = '0;
  endtask

  // One boundary strobe; returns outputs seen in the boundary cycle.
  task automatic boundary(input logic [31:0] pc, output logic take,
                          output logic [31:0] rpc, output logic wr,
                          output logic [4:0] idx, output logic [31:0] rdat);
    instrDone = 1'b1; curPc = pc; #1;
    take = redirectValid; rpc = redirectPc; wr = excAddrWrEn;
    idx = excAddrIdx; rdat = excAddrData;
    @(posedge clk); @(negedge clk);
    instrDone = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int a = 0; a < 4; a++) begin
      csrRead(2'(a), d);
      check("R1 reg after reset", d, 32'h0);
    end
    check("R1 no redirect", {31'b0, redirectValid}, 32'h0);
  endtask

  task automatic t_pending();
    logic [31:0] d;
    pulseLines(32'h0000_0020);
    csrRead(2'd0, d);
    check("R2 line5 sets bit5", d, 32'h0000_0020);
    repeat (3) @(negedge clk);
    csrRead(2'd0, d);
    check("R3 bit5 sticky", d, 32'h0000_0020);
    pulseLines(32'h8000_0000);
    csrRead(2'd0, d);
    check("R2 line31 sets bit31", d, 32'h8000_0020);
  endtask

  task automatic t_clear();
    logic [31:0] d;
    csrWrite(2'd0, 32'h0000_0020);
    csrRead(2'd0, d);
    check("R4 w1c bit5 only", d, 32'h8000_0000);
    irqLines = 32'h8000_0000;
    csrWrite(2'd0, 32'h8000_0000);
    irqLines = '0;
    csrRead(2'd0, d);
    check("R4 set wins over clear", d, 32'h8000_0000);
    csrWrite(2'd0, 32'hFFFF_FFFF);
    csrRead(2'd0, d);
    check("R4 clear all", d, 32'h0);
  endtask

  task automatic t_entry();
    logic [31:0] d, rpc, rdat;
    logic take, wr;
    logic [4:0] idx;
    csrWrite(2'd3, 32'h1234_5678);
    csrRead(2'd3, d);
    check("R9 base low bits zero", d, 32'h1234_5600);
    // masked: enable on, mask empty
    csrWrite(2'd2, 32'h1);
    pulseLines(32'h0000_0008);
    boundary(32'h0000_1000, take, rpc, wr, idx, rdat);
    check("R5 masked no entry", {31'b0, take}, 32'h0);
    // enable off, line held high and unmasked
    csrWrite(2'd2, 32'h0);
    csrWrite(2'd1, 32'h0000_0008);
    irqLines = 32'h0000_0008;
    @(posedge clk); @(negedge clk);
    boundary(32'h0000_1004, take, rpc, wr, idx, rdat);
    check("R5 enable off no entry", {31'b0, take}, 32'h0);
    csrWrite(2'd2, 32'h1);
    boundary(32'h0000_2468, take, rpc, wr, idx, rdat);
    check("R7 redirect valid", {31'b0, take}, 32'h1);
    check("R7 vector", rpc, 32'h1234_56C0);
    check("R6 ret write en", {31'b0, wr}, 32'h1);
    check("R6 ret reg idx", {27'b0, idx}, 32'd30);
    check("R6 ret data", rdat, 32'h0000_2468);
    csrRead(2'd2, d);
    check("R8 status after entry", d, 32'h2);
    boundary(32'h0000_3000, take, rpc, wr, idx, rdat);
    check("R5 no reentry with enable cleared", {31'b0, take}, 32'h0);
  endtask

  task automatic t_rearm();
    logic [31:0] rpc, rdat;
    logic take, wr;
    logic [4:0] idx;
    irqLines = '0;
    @(posedge clk); @(negedge clk);
    boundary(32'h0000_4000, take, rpc, wr, idx, rdat);
    csrWrite(2'd2, 32'h1);
    repeat (2) @(negedge clk);
    boundary(32'h0000_4004, take, rpc, wr, idx, rdat);
    check("R10 disarmed no entry", {31'b0, take}, 32'h0);
    pulseLines(32'h0000_0080);
    boundary(32'h0000_4008, take, rpc, wr, idx, rdat);
    check("R10 rearmed entry", {31'b0, take}, 32'h1);
    check("R10 rearmed ret data", rdat, 32'h0000_4008);
  endtask

  task automatic t_no_boundary();
    logic seen = 1'b0;
    csrWrite(2'd2, 32'h1);
    pulseLines(32'h0000_0008);
    for (int i = 0; i < 6; i++) begin
      #1;
      if (redirectValid || excAddrWrEn) seen = 1'b1;
      @(negedge clk);
    end
    check("R11 no entry without boundary", {31'b0, seen}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_pending();
    t_clear();
    t_entry();
    t_rearm();
    t_no_boundary();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule